// File: doc/BRIEF.md
# Transmit Buffer Free-Space Tracker

This block keeps a running count of the free bytes in the buffer region of one asynchronous transmit channel. Software posts packets of known byte size. Each post lowers the free total, and the size is saved in a small ring that the write packet counter indexes. A downstream consumer drains the packets and exposes a packet read counter, masked to the ring width.

On a query, the tracker replays the saved sizes one entry per clock. It does this until its own masked read counter matches the consumer's counter. Each replayed size goes back into the free total. The tracker then returns either the free space, or zero if the ring of outstanding packets is full.

Only one channel is tracked at a time. Initialising with channel number zero turns tracking off. A query for any channel other than the tracked one returns the all-ones marker at once.

Top module: `txfill_tracker`

## Requirements
- R1: An init pulse loads the free total with `init_size`, records `init_chan` as the tracked channel, and loads both the write and read packet counters with `hw_rpc` zero-extended to 16 bits; a query right after with unchanged `hw_rpc` returns `init_size`.
- R2: An enqueue on a tracked channel stores `enq_size` in ring slot (write counter AND `RING_MASK`), subtracts it from the free total and increments the write counter.
- R3: A query on the tracked channel reclaims exactly one ring entry per clock while (read counter AND `RING_MASK`) differs from `hw_rpc`, adding the stored size back and incrementing the read counter; with k entries to reclaim, `qry_done` is high in the cycle after the (k+1)-th rising edge following the edge that accepted the query.
- R4: When reclaiming ends and (write counter − read counter), taken modulo 2^16, is at least `RING_MASK`, the reported space is 0.
- R5: A query whose channel differs from the tracked channel returns `qry_space` = 16'hFFFF with `qry_done` high in the cycle right after the accepting edge.
- R6: After an init with `init_chan` = 0, every query, including one for the previously tracked channel, returns 16'hFFFF.
- R7: `qry_done` is low after reset, lasts one cycle per accepted query, and a query raised while `qry_busy` is high is ignored and produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_valid | input | 1 | Load tracking state (highest priority) |
| init_chan | input | CHAN_W | Channel to track; 0 disables tracking |
| init_size | input | SIZE_W | Byte size of the channel's buffer region |
| hw_rpc | input | RING_W | Consumer's masked read packet counter |
| enq_valid | input | 1 | Software posts a packet |
| enq_size | input | SIZE_W | Byte size of the posted packet |
| qry_valid | input | 1 | Request free space |
| qry_chan | input | CHAN_W | Channel addressed by the query |
| qry_busy | output | 1 | Reclaim in progress; new queries are ignored |
| qry_done | output | 1 | One-cycle strobe: `qry_space` is valid |
| qry_space | output | SIZE_W | Free bytes, 0 when full, all ones on a miss |

## Verification
Directed sequences cover several cases: a query straight after init, queries for a foreign channel and after disabling, and a ring filled to the full threshold and then drained by one entry. These separate the space arithmetic from the full-ring override and the miss marker. Reclaim distances from zero to several entries set the done latency apart from the replay count, and a second query raised during a reclaim shows it is ignored. A seeded random mix of enqueues and queries, with consumer counters at random reachable distances, checks that ring slots wrap around and are reused correctly over many turns.

// File: rtl/txfill_pkg.sv
package txfill_pkg;

    typedef enum logic [0:0] {
        QS_IDLE    = 1'b0,
        QS_RECLAIM = 1'b1
    } qry_state_e;

endpackage

// File: rtl/txfill_ring.sv
module txfill_ring #(
    parameter int SIZE_W = 16,
    parameter int RING_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RING_W-1:0] wr_idx,
    input  logic [SIZE_W-1:0] wr_data,
    input  logic [RING_W-1:0] rd_idx,
    output logic [SIZE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << RING_W;

    logic [DEPTH-1:0][SIZE_W-1:0] slot_d, slot_q;
    logic [DEPTH-1:0]             slot_we;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot_we
        assign slot_we[g] = wr_en && (wr_idx == RING_W'(g));
    end

    always_comb begin
        slot_d = slot_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) begin
                slot_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_idx];

    AST_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slot_q[$past(wr_idx)] == $past(wr_data)); // R2

endmodule

// File: rtl/txfill_acct.sv
module txfill_acct #(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 16,
    parameter int CHAN_W = 6,
    parameter int RING_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [CHAN_W-1:0] init_chan,
    input  logic [SIZE_W-1:0] init_size,
    input  logic [RING_W-1:0] hw_rpc,
    input  logic              enq_valid,
    input  logic [SIZE_W-1:0] enq_size,
    input  logic              step,
    input  logic [SIZE_W-1:0] step_size,
    output logic              enq_fire,
    output logic [CHAN_W-1:0] track_chan,
    output logic [SIZE_W-1:0] free_bytes,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic [CNT_W-1:0]  rd_cnt
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [SIZE_W-1:0] free;
        logic [CNT_W-1:0]  wr;
        logic [CNT_W-1:0]  rd;
    } acct_t;

    acct_t acct_d, acct_q;
    logic  track_on;
    logic [SIZE_W-1:0] sub_bytes, add_bytes;

    assign track_on = (acct_q.chan != '0);
    assign enq_fire = enq_valid && track_on && !init_valid;

    always_comb begin
        acct_d    = acct_q;
        sub_bytes = enq_fire ? enq_size : '0;
        add_bytes = step ? step_size : '0;
        if (init_valid) begin
            acct_d.chan = init_chan;
            acct_d.free = init_size;
            acct_d.wr   = {{(CNT_W-RING_W){1'b0}}, hw_rpc};
            acct_d.rd   = {{(CNT_W-RING_W){1'b0}}, hw_rpc};
        end else begin
            acct_d.free = acct_q.free - sub_bytes + add_bytes;
            if (enq_fire) begin
                acct_d.wr = acct_q.wr + CNT_ONE;
            end
            if (step) begin
                acct_d.rd = acct_q.rd + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acct_q <= '0;
        end else begin
            acct_q <= acct_d;
        end
    end

    assign track_chan = acct_q.chan;
    assign free_bytes = acct_q.free;
    assign wr_cnt     = acct_q.wr;
    assign rd_cnt     = acct_q.rd;

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> (free_bytes == $past(init_size)) && (rd_cnt == wr_cnt)
                       && (rd_cnt[RING_W-1:0] == $past(hw_rpc))); // R1
    AST_ENQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        enq_fire |=> wr_cnt == $past(wr_cnt) + CNT_ONE); // R2
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init_valid) |=> rd_cnt == $past(rd_cnt) + CNT_ONE); // R3

endmodule

// File: rtl/txfill_query.sv
module txfill_query
    import txfill_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SIZE_W    = 16,
    parameter int CHAN_W    = 6,
    parameter int RING_W    = 3,
    parameter int RING_MASK = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic              qry_valid,
    input  logic [CHAN_W-1:0] qry_chan,
    input  logic [CHAN_W-1:0] track_chan,
    input  logic [RING_W-1:0] hw_rpc,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [CNT_W-1:0]  rd_cnt,
    input  logic [SIZE_W-1:0] free_bytes,
    output logic              step,
    output logic              busy,
    output logic              done,
    output logic [SIZE_W-1:0] space
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(RING_MASK);

    typedef struct packed {
        qry_state_e        state;
        logic              done;
        logic [SIZE_W-1:0] space;
    } qry_t;

    qry_t qry_d, qry_q;
    logic hit, pending, full;
    logic [CNT_W-1:0] outstanding;

    assign hit         = (track_chan != '0) && (qry_chan == track_chan);
    assign pending     = (rd_cnt[RING_W-1:0] != hw_rpc);
    assign outstanding = wr_cnt - rd_cnt;
    assign full        = (outstanding >= FULL_LVL);

    always_comb begin
        qry_d      = qry_q;
        qry_d.done = 1'b0;
        step       = 1'b0;
        if (init_valid) begin
            qry_d.state = QS_IDLE;
        end else begin
            unique case (qry_q.state)
                QS_IDLE: begin
                    if (qry_valid) begin
                        if (hit) begin
                            qry_d.state = QS_RECLAIM;
                        end else begin
                            qry_d.done  = 1'b1;
                            qry_d.space = '1;
                        end
                    end
                end
                QS_RECLAIM: begin
                    if (pending) begin
                        step = 1'b1;
                    end else begin
                        qry_d.state = QS_IDLE;
                        qry_d.done  = 1'b1;
                        qry_d.space = full ? '0 : free_bytes;
                    end
                end
                default: qry_d.state = QS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qry_q <= '{state: QS_IDLE, done: 1'b0, space: '0};
        end else begin
            qry_q <= qry_d;
        end
    end

    assign busy  = (qry_q.state == QS_RECLAIM);
    assign done  = qry_q.done;
    assign space = qry_q.space;

    AST_STEP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> busy); // R3
    AST_FULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pending && full && !init_valid) |=> (done && space == '0)); // R4
    AST_MISS_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid && !busy && !hit && !init_valid) |=> (done && space == '1)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

endmodule

// File: rtl/txfill_tracker.sv
module txfill_tracker #(
    parameter int CNT_W     = 16,
    parameter int SIZE_W    = 16,
    parameter int CHAN_W    = 6,
    parameter int RING_MASK = 7,
    localparam int RING_W   = $clog2(RING_MASK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [CHAN_W-1:0] init_chan,
    input  logic [SIZE_W-1:0] init_size,
    input  logic [RING_W-1:0] hw_rpc,
    input  logic              enq_valid,
    input  logic [SIZE_W-1:0] enq_size,
    input  logic              qry_valid,
    input  logic [CHAN_W-1:0] qry_chan,
    output logic              qry_busy,
    output logic              qry_done,
    output logic [SIZE_W-1:0] qry_space
);

    logic              enq_fire, step;
    logic [CHAN_W-1:0] track_chan;
    logic [SIZE_W-1:0] free_bytes, slot_size;
    logic [CNT_W-1:0]  wr_cnt, rd_cnt;

    txfill_acct #(
        .CNT_W (CNT_W), .SIZE_W(SIZE_W), .CHAN_W(CHAN_W), .RING_W(RING_W)
    ) i_acct (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_valid (init_valid),
        .init_chan  (init_chan),
        .init_size  (init_size),
        .hw_rpc     (hw_rpc),
        .enq_valid  (enq_valid),
        .enq_size   (enq_size),
        .step       (step),
        .step_size  (slot_size),
        .enq_fire   (enq_fire),
        .track_chan (track_chan),
        .free_bytes (free_bytes),
        .wr_cnt     (wr_cnt),
        .rd_cnt     (rd_cnt)
    );

    txfill_ring #(
        .SIZE_W(SIZE_W), .RING_W(RING_W)
    ) i_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (enq_fire),
        .wr_idx  (wr_cnt[RING_W-1:0]),
        .wr_data (enq_size),
        .rd_idx  (rd_cnt[RING_W-1:0]),
        .rd_data (slot_size)
    );

    txfill_query #(
        .CNT_W(CNT_W), .SIZE_W(SIZE_W), .CHAN_W(CHAN_W),
        .RING_W(RING_W), .RING_MASK(RING_MASK)
    ) i_query (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_valid (init_valid),
        .qry_valid  (qry_valid),
        .qry_chan   (qry_chan),
        .track_chan (track_chan),
        .hw_rpc     (hw_rpc),
        .wr_cnt     (wr_cnt),
        .rd_cnt     (rd_cnt),
        .free_bytes (free_bytes),
        .step       (step),
        .busy       (qry_busy),
        .done       (qry_done),
        .space      (qry_space)
    );

endmodule

// File: tb/test_txfill_tracker.sv
module test_txfill_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_valid = 1'b0;
    logic [5:0]  init_chan = '0;
    logic [15:0] init_size = '0;
    logic [2:0]  hw_rpc = '0;
    logic        enq_valid = 1'b0;
    logic [15:0] enq_size = '0;
    logic        qry_valid = 1'b0;
    logic [5:0]  qry_chan = '0;
    logic        qry_busy, qry_done;
    logic [15:0] qry_space;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int          m_chan;
    int          m_free;
    logic [15:0] m_wr, m_rd;
    int          m_ring [8];

    always #5 clk = ~clk;

    txfill_tracker i_txfill_tracker (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_chan(init_chan),
        .init_size(init_size), .hw_rpc(hw_rpc), .enq_valid(enq_valid),
        .enq_size(enq_size), .qry_valid(qry_valid), .qry_chan(qry_chan),
        .qry_busy(qry_busy), .qry_done(qry_done), .qry_space(qry_space)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outstanding();
        logic [15:0] d;
        d = m_wr - m_rd;
        return int'(d);
    endfunction

    task automatic do_init(input int chan, input int size, input int hw);
        init_valid = 1'b1;
        init_chan  = 6'(chan);
        init_size  = 16'(size);
        hw_rpc     = 3'(hw);
        @(negedge clk);
        init_valid = 1'b0;
        m_chan = chan;
        m_free = size;
        m_wr   = 16'(hw);
        m_rd   = 16'(hw);
    endtask

    task automatic do_enq(input int size);
        enq_valid = 1'b1;
        enq_size  = 16'(size);
        @(negedge clk);
        enq_valid = 1'b0;
        if (m_chan != 0) begin
            m_ring[int'(m_wr[2:0])] = size;
            m_free = m_free - size;
            m_wr   = m_wr + 16'd1;
        end
    endtask

    // Query; k = number of entries the model reclaims; double = re-raise while busy
    task automatic do_query(input int chan, input int hw, input bit double, input string req);
        bit hit;
        int k, lat, exp_space, extra;
        hit = (m_chan != 0) && (chan == m_chan);
        k = 0;
        if (hit) begin
            while (m_rd[2:0] != 3'(hw)) begin
                m_free = m_free + m_ring[int'(m_rd[2:0])];
                m_rd   = m_rd + 16'd1;
                k++;
            end
            exp_space = (outstanding() >= 7) ? 0 : (m_free & 16'hFFFF);
        end else begin
            exp_space = 16'hFFFF;
        end
        qry_valid = 1'b1;
        qry_chan  = 6'(chan);
        hw_rpc    = 3'(hw);
        @(negedge clk);
        qry_valid = double;
        lat = 0;
        while (!qry_done && lat < 40) begin
            @(negedge clk);
            qry_valid = 1'b0;
            lat++;
        end
        qry_valid = 1'b0;
        check(qry_done === 1'b1 && lat == (hit ? k + 1 : 0), {req, " latency"}, lat, hit ? k + 1 : 0);
        check(qry_space === 16'(exp_space), {req, " space"}, int'(qry_space), exp_space);
        @(negedge clk);
        check(qry_done === 1'b0, "R7 done single pulse", int'(qry_done), 0);
        if (double) begin
            extra = 0;
            for (int i = 0; i < 6; i++) begin
                if (qry_done) extra++;
                @(negedge clk);
            end
            check(extra == 0, "R7 busy query ignored", extra, 0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int seed_dummy;
        m_chan = 0; m_free = 0; m_wr = '0; m_rd = '0;
        foreach (m_ring[i]) m_ring[i] = 0;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(qry_done === 1'b0 && qry_busy === 1'b0, "R7 reset state", int'(qry_done), 0);

        // R1: init then immediate query
        do_init(5, 200, 3);
        do_query(5, 3, 1'b0, "R1");
        // R5: foreign channel
        do_query(6, 3, 1'b0, "R5");
        // R2: enqueues reduce space
        do_enq(30); do_enq(50); do_enq(20);
        do_query(5, 3, 1'b0, "R2");
        // R3: reclaim two entries
        do_query(5, 5, 1'b0, "R3");
        // R4: fill to threshold
        for (int i = 0; i < 6; i++) do_enq(10);
        do_query(5, 5, 1'b0, "R4 full");
        do_query(5, 6, 1'b0, "R4 below full");
        // R7: second query while busy
        do_query(5, 0, 1'b1, "R7 busy");
        // R6: disable
        do_init(0, 500, 2);
        do_query(5, 2, 1'b0, "R6 old chan");
        do_query(0, 2, 1'b0, "R6 chan zero");

        // Random phase with wrap-around
        do_init(9, 2000, int'($urandom_range(0, 7)));
        for (int n = 0; n < 150; n++) begin
            if ($urandom_range(0, 2) != 0 && outstanding() < 7 && m_free > 100) begin
                do_enq(int'($urandom_range(1, 100)));
            end else begin
                int k;
                k = int'($urandom_range(0, outstanding()));
                if ($urandom_range(0, 9) == 0) begin
                    do_query(int'($urandom_range(10, 20)), int'(m_rd[2:0]), 1'b0, "R5 random");
                end else begin
                    do_query(9, int'(3'(m_rd[2:0] + 3'(k))), 1'b0, "R3 random");
                end
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule